// File: doc/BRIEF.md
# Interrupt Vector Ring Writer

This block takes interrupt events from on-chip sources and turns each one into a 16-byte vector. It writes each vector into a circular buffer in host memory, one 32-bit word at a time, over a simple valid/ready memory-write port. The block owns the write pointer. The host owns the read pointer and moves it forward as it consumes vectors. The interrupt line is raised while unread vectors remain, and it is gated by an arming flag that a read-pointer update can clear or re-arm.

Both pointers count bytes. The ring length is programmed as the base-2 logarithm of its size in 32-bit words. If the ring fills, new vectors overwrite the oldest ones, and a sticky overflow flag is placed in bit 0 of the write-pointer value. When writeback is enabled, that write-pointer value, including the overflow flag, is written to a second memory address after every vector. The host can then poll memory instead of reading the register.

Top module: `ivr_writer`

## Requirements
- R1: An accepted event becomes four word writes at consecutive byte addresses starting at ring_base + write pointer, in this order:
  - word 0 = {24'b0, src_id}
  - word 1 = {4'b0, src_data}
  - word 2 = {pasid, vm_id, ring_id}
  - word 3 = 0
- R2: The write pointer is a byte offset. It grows by 16 per vector and wraps to 0 at 4<<size bytes. A register write to it loads the written value, masked to the ring, and leaves it unchanged otherwise.
- R3: The ring base is {base register, 8'h00}. The base register holds address bits [39:8].
- R4: With overflow detection on, a vector whose completion makes the write pointer equal the read pointer sets bit 0 of the write-pointer register. Later vectors are still written and overwrite the oldest slots.
- R5: The overflow flag stays set until a control write with bit 5 set. That bit is a strobe and reads as 0.
- R6: With writeback on, each vector is followed by one extra word write of the write-pointer register value (overflow bit included) to {wb_hi[7:0], wb_lo}.
- R7: Events are accepted only while the ring is enabled. ev_ready is low whenever a vector word or writeback word is outstanding.
- R8: The irq output is high only when all three hold: interrupts are enabled, the masked pointers differ, and the ring is armed. A vector arms it. A read-pointer write with re-arm off disarms it until the next vector.
- R9: With re-arm on, a read-pointer write that leaves the pointers unequal keeps irq asserted. A write that makes them equal drops it.
- R10: busy is high while the pointers differ or a memory write is in progress, and low otherwise.
- R11: A memory request holds mem_valid, mem_addr and mem_data unchanged until mem_ready is seen.
- R12: After reset, all of the following are low or zero:
  - every register
  - ev_ready, irq, busy and mem_valid

  Register word offsets on reg_addr:

  | Offset | Register |
  |---|---|
  | 0 | control |
  | 1 | base |
  | 2 | read pointer |
  | 3 | write pointer |
  | 4 | writeback low |
  | 5 | writeback high |
  | 6 | status (bit 0 = busy) |

  Read data appears on the clock after the address is applied.
- R13: Control register bits:

  | Bits | Function |
  |---|---|
  | 0 | ring enable |
  | 1 | interrupt enable |
  | 2 | overflow detect |
  | 3 | writeback enable |
  | 4 | re-arm enable |
  | 12:8 | size (log2 of ring words), clamped to [2, PTR_W-2] |

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| ev_valid | input | 1 | Event offered |
| ev_ready | output | 1 | Event can be taken |
| ev_src_id | input | 8 | Source identifier |
| ev_src_data | input | 28 | Source payload |
| ev_ring_id | input | 8 | Ring identifier |
| ev_vm_id | input | 8 | Virtual machine identifier |
| ev_pasid | input | 16 | Process address space identifier |
| mem_valid | output | 1 | Memory write request |
| mem_ready | input | 1 | Memory write accepted |
| mem_addr | output | ADDR_W (40) | Byte address of the word |
| mem_data | output | 32 | Word to write |
| irq | output | 1 | Interrupt to host |
| busy | output | 1 | Vectors pending or writes in progress |

## Verification
The hardest state to reach from the ports is an overflow that coincides with writeback. That needs a wrapped ring, a read pointer held still, and the mirrored word carrying the overflow bit while memory stalls at random. The stimulus holds the read pointer fixed at an arbitrary slot and pushes exactly one ring's worth of vectors. Then it turns writeback on and pushes around the ring again, so the overflowing vector's mirror word is checked. Re-arm is reached by moving the read pointer only partway through two pending vectors.

// File: rtl/ivr_pkg.sv
package ivr_pkg;

  localparam int DATA_W    = 32;
  localparam int REG_AW    = 3;
  localparam int BASE_LSB  = 8;
  localparam int VEC_WORDS = 4;
  localparam int VEC_BYTES = VEC_WORDS * 4;
  localparam int SIZE_W    = 5;

  // register word offsets
  localparam logic [REG_AW-1:0] RA_CTRL = 3'd0;
  localparam logic [REG_AW-1:0] RA_BASE = 3'd1;
  localparam logic [REG_AW-1:0] RA_RPTR = 3'd2;
  localparam logic [REG_AW-1:0] RA_WPTR = 3'd3;
  localparam logic [REG_AW-1:0] RA_WBLO = 3'd4;
  localparam logic [REG_AW-1:0] RA_WBHI = 3'd5;
  localparam logic [REG_AW-1:0] RA_STAT = 3'd6;

  // control bit positions
  localparam int CB_RING     = 0;
  localparam int CB_INTR     = 1;
  localparam int CB_OVFDET   = 2;
  localparam int CB_WB       = 3;
  localparam int CB_REARM    = 4;
  localparam int CB_OVFCLR   = 5;
  localparam int CB_SIZE_LSB = 8;

  typedef struct packed {
    logic [SIZE_W-1:0] size_log2;
    logic              rearm_en;
    logic              wb_en;
    logic              ovf_det_en;
    logic              intr_en;
    logic              ring_en;
  } ctrl_t;

  typedef struct packed {
    logic [7:0]  src_id;
    logic [27:0] src_data;
    logic [7:0]  ring_id;
    logic [7:0]  vm_id;
    logic [15:0] pasid;
  } event_t;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_VEC   = 2'd1,
    S_WBSET = 2'd2,
    S_WB    = 2'd3
  } seq_state_e;

endpackage

// File: rtl/ivr_regs.sv
module ivr_regs
  import ivr_pkg::*;
#(
  parameter int PTR_W  = 18,
  parameter int ADDR_W = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [DATA_W-1:0] wptr_img,
  input  logic              busy,
  output ctrl_t             ctrl,
  output logic [ADDR_W-BASE_LSB-1:0] base,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [PTR_W-1:0]  rptr,
  output logic              rptr_wr,
  output logic              wptr_wr,
  output logic              ovf_clr
);

  localparam int BASE_W = ADDR_W - BASE_LSB;
  localparam int WBHI_W = ADDR_W - DATA_W;

  logic [DATA_W-1:0] wblo_q;
  logic [WBHI_W-1:0] wbhi_q;

  assign rptr_wr = reg_we && (reg_addr == RA_RPTR);
  assign wptr_wr = reg_we && (reg_addr == RA_WPTR);
  assign ovf_clr = reg_we && (reg_addr == RA_CTRL) && reg_wdata[CB_OVFCLR];
  assign wb_addr = {wbhi_q, wblo_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl   <= '0;
      base   <= '0;
      rptr   <= '0;
      wblo_q <= '0;
      wbhi_q <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        RA_CTRL: begin
          ctrl.size_log2  <= reg_wdata[CB_SIZE_LSB +: SIZE_W];
          ctrl.rearm_en   <= reg_wdata[CB_REARM];
          ctrl.wb_en      <= reg_wdata[CB_WB];
          ctrl.ovf_det_en <= reg_wdata[CB_OVFDET];
          ctrl.intr_en    <= reg_wdata[CB_INTR];
          ctrl.ring_en    <= reg_wdata[CB_RING];
        end
        RA_BASE: base   <= reg_wdata[BASE_W-1:0];
        RA_RPTR: rptr   <= {reg_wdata[PTR_W-1:4], 4'b0000};
        RA_WBLO: wblo_q <= reg_wdata;
        RA_WBHI: wbhi_q <= reg_wdata[WBHI_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      case (reg_addr)
        RA_CTRL: reg_rdata <= DATA_W'({ctrl.size_log2, 3'b000, ctrl.rearm_en,
                                       ctrl.wb_en, ctrl.ovf_det_en,
                                       ctrl.intr_en, ctrl.ring_en});
        RA_BASE: reg_rdata <= DATA_W'(base);
        RA_RPTR: reg_rdata <= DATA_W'(rptr);
        RA_WPTR: reg_rdata <= wptr_img;
        RA_WBLO: reg_rdata <= wblo_q;
        RA_WBHI: reg_rdata <= DATA_W'(wbhi_q);
        RA_STAT: reg_rdata <= DATA_W'(busy);
        default: reg_rdata <= '0;
      endcase
    end
  end

endmodule

// File: rtl/ivr_ptr.sv
module ivr_ptr
  import ivr_pkg::*;
#(
  parameter int PTR_W = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  ctrl_t            ctrl,
  input  logic [PTR_W-1:0] rptr,
  input  logic             rptr_wr,
  input  logic             wptr_wr,
  input  logic [PTR_W-1:0] wr_val,
  input  logic             ovf_clr,
  input  logic             commit,
  output logic [PTR_W-1:0] wptr,
  output logic             ovf,
  output logic             pending,
  output logic             irq
);

  localparam int SZ_MIN = 2;
  localparam int SZ_MAX = PTR_W - 2;

  logic [SIZE_W-1:0] sz;
  logic [PTR_W:0]    span;
  logic [PTR_W-1:0]  mask, wptr_q, wptr_m, rptr_m, next_w;
  logic              armed_q, irq_q;

  always_comb begin
    if (int'(ctrl.size_log2) < SZ_MIN)      sz = SIZE_W'(SZ_MIN);
    else if (int'(ctrl.size_log2) > SZ_MAX) sz = SIZE_W'(SZ_MAX);
    else                                     sz = ctrl.size_log2;
  end

  assign span    = (PTR_W+1)'(4) << sz;
  assign mask    = (span[PTR_W-1:0] - PTR_W'(1)) & ~PTR_W'(VEC_BYTES - 1);
  assign wptr_m  = wptr_q & mask;
  assign rptr_m  = rptr & mask;
  assign next_w  = (wptr_m + PTR_W'(VEC_BYTES)) & mask;
  assign pending = (wptr_m != rptr_m);
  assign wptr    = wptr_m;
  assign irq     = irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr_q  <= '0;
      ovf     <= 1'b0;
      armed_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      if (wptr_wr)     wptr_q <= wr_val & mask;
      else if (commit) wptr_q <= next_w;

      if (commit && ctrl.ovf_det_en && (next_w == rptr_m)) ovf <= 1'b1;
      else if (ovf_clr)                                  ovf <= 1'b0;

      if (commit)       armed_q <= 1'b1;
      else if (rptr_wr) armed_q <= ctrl.rearm_en;

      irq_q <= ctrl.intr_en && armed_q && pending;
    end
  end

  // R2
  wptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!commit && !wptr_wr) |=> $stable(wptr_q));

  // R5
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (ovf && !ovf_clr) |=> ovf);

  // R8
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> $past(ctrl.intr_en));

endmodule

// File: rtl/ivr_seq.sv
module ivr_seq
  import ivr_pkg::*;
#(
  parameter int PTR_W  = 18,
  parameter int ADDR_W = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ring_en,
  input  logic              wb_en,
  input  logic              ev_valid,
  input  event_t            ev,
  output logic              ev_ready,
  input  logic [ADDR_W-1:0] ring_base,
  input  logic [PTR_W-1:0]  wptr,
  input  logic [ADDR_W-1:0] wb_addr,
  input  logic [DATA_W-1:0] wb_data,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_data,
  output logic              commit,
  output logic              active
);

  localparam int IDX_W = $clog2(VEC_WORDS);

  seq_state_e                         st_q;
  logic [IDX_W-1:0]                   idx_q;
  logic [VEC_WORDS-1:0][DATA_W-1:0]   vec_q, vec_in;
  logic                               take;

  assign ev_ready = (st_q == S_IDLE) && ring_en;
  assign take     = ev_valid && ev_ready;
  assign commit   = (st_q == S_VEC) && mem_ready && (idx_q == IDX_W'(VEC_WORDS - 1));
  assign active   = (st_q != S_IDLE);

  always_comb begin
    vec_in    = '0;
    vec_in[0] = DATA_W'(ev.src_id);
    vec_in[1] = DATA_W'(ev.src_data);
    vec_in[2] = {ev.pasid, ev.vm_id, ev.ring_id};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= S_IDLE;
      idx_q     <= '0;
      vec_q     <= '0;
      mem_valid <= 1'b0;
      mem_addr  <= '0;
      mem_data  <= '0;
    end else begin
      case (st_q)
        S_IDLE: if (take) begin
          vec_q     <= vec_in;
          mem_valid <= 1'b1;
          mem_addr  <= ring_base + ADDR_W'(wptr);
          mem_data  <= vec_in[0];
          idx_q     <= '0;
          st_q      <= S_VEC;
        end
        S_VEC: if (mem_ready) begin
          if (idx_q == IDX_W'(VEC_WORDS - 1)) begin
            mem_valid <= 1'b0;
            st_q      <= wb_en ? S_WBSET : S_IDLE;
          end else begin
            idx_q    <= idx_q + IDX_W'(1);
            mem_addr <= mem_addr + ADDR_W'(4);
            mem_data <= vec_q[idx_q + IDX_W'(1)];
          end
        end
        S_WBSET: begin
          mem_valid <= 1'b1;
          mem_addr  <= wb_addr;
          mem_data  <= wb_data;
          st_q      <= S_WB;
        end
        S_WB: if (mem_ready) begin
          mem_valid <= 1'b0;
          st_q      <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  // R11
  mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data)));

  // R7
  ready_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ev_ready |-> !mem_valid);

  // R1
  accept_launch_chk: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && ev_ready) |=> mem_valid);

endmodule

// File: rtl/ivr_writer.sv
module ivr_writer
  import ivr_pkg::*;
#(
  parameter int PTR_W  = 18,
  parameter int ADDR_W = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              ev_valid,
  output logic              ev_ready,
  input  logic [7:0]        ev_src_id,
  input  logic [27:0]       ev_src_data,
  input  logic [7:0]        ev_ring_id,
  input  logic [7:0]        ev_vm_id,
  input  logic [15:0]       ev_pasid,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_data,
  output logic              irq,
  output logic              busy
);

  localparam int BASE_W = ADDR_W - BASE_LSB;

  ctrl_t              ctrl;
  logic [BASE_W-1:0]  base;
  logic [ADDR_W-1:0]  wb_addr, ring_base;
  logic [PTR_W-1:0]   rptr, wptr;
  logic               rptr_wr, wptr_wr, ovf_clr, ovf, pending, commit, active;
  logic [DATA_W-1:0]  wptr_img;
  logic               busy_q;
  event_t             ev;

  assign ring_base = {base, {BASE_LSB{1'b0}}};
  assign wptr_img  = DATA_W'(wptr) | DATA_W'(ovf);
  assign ev        = '{src_id: ev_src_id, src_data: ev_src_data, ring_id: ev_ring_id,
                       vm_id: ev_vm_id, pasid: ev_pasid};
  assign busy      = busy_q;

  always_ff @(posedge clk) begin
    if (rst) busy_q <= 1'b0;
    else     busy_q <= pending || active;
  end

  ivr_regs #(.PTR_W(PTR_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wptr_img(wptr_img),
    .busy(busy_q), .ctrl(ctrl), .base(base), .wb_addr(wb_addr), .rptr(rptr),
    .rptr_wr(rptr_wr), .wptr_wr(wptr_wr), .ovf_clr(ovf_clr)
  );

  ivr_ptr #(.PTR_W(PTR_W)) u_ptr (
    .clk(clk), .rst(rst), .ctrl(ctrl), .rptr(rptr), .rptr_wr(rptr_wr),
    .wptr_wr(wptr_wr), .wr_val(reg_wdata[PTR_W-1:0]), .ovf_clr(ovf_clr),
    .commit(commit), .wptr(wptr), .ovf(ovf), .pending(pending), .irq(irq)
  );

  ivr_seq #(.PTR_W(PTR_W), .ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst(rst), .ring_en(ctrl.ring_en), .wb_en(ctrl.wb_en),
    .ev_valid(ev_valid), .ev(ev), .ev_ready(ev_ready), .ring_base(ring_base),
    .wptr(wptr), .wb_addr(wb_addr), .wb_data(wptr_img), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data),
    .commit(commit), .active(active)
  );

  // R10
  busy_follow_chk: assert property (@(posedge clk) disable iff (rst)
    mem_valid |=> busy);

endmodule

// File: tb/test_ivr_writer.sv
module test_ivr_writer;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 40;
  localparam int RING_BYTES = 64;               // size field 4 -> 16 words
  localparam logic [31:0] BASEV = 32'h00AB_CDE0;
  localparam logic [39:0] WBA   = 40'h5A_00C0_FFE0;
  localparam logic [31:0] C_RING = 32'h1, C_INTR = 32'h2, C_OVF = 32'h4,
                          C_WB = 32'h8, C_REARM = 32'h10, C_CLR = 32'h20,
                          C_SIZE = 32'h400;

  logic clk = 0, rst = 1;
  logic reg_we = 0; logic [2:0] reg_addr = 0; logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic ev_valid = 0, ev_ready;
  logic [7:0] ev_src_id = 0, ev_ring_id = 0, ev_vm_id = 0;
  logic [27:0] ev_src_data = 0; logic [15:0] ev_pasid = 0;
  logic mem_valid, mem_ready = 0, irq, busy;
  logic [ADDR_W-1:0] mem_addr; logic [31:0] mem_data;

  int n_checks = 0, n_err = 0, wr_count = 0, stab_err = 0, overlap_err = 0;
  bit done = 0;
  logic [31:0] mem_model [logic [39:0]];
  logic [31:0] exp_wptr = 0, exp_rptr = 0;
  logic exp_ovf = 0, ovfdet_on = 0, wb_on = 0;
  logic stall_prev = 0; logic [39:0] p_addr = 0; logic [31:0] p_data = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ivr_writer i_ivr_writer (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_valid(ev_valid),
    .ev_ready(ev_ready), .ev_src_id(ev_src_id), .ev_src_data(ev_src_data),
    .ev_ring_id(ev_ring_id), .ev_vm_id(ev_vm_id), .ev_pasid(ev_pasid),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
    .mem_data(mem_data), .irq(irq), .busy(busy)
  );

  always @(negedge clk) mem_ready = ($urandom % 4) != 0;

  always @(posedge clk) if (!rst) begin
    if (stall_prev && (!mem_valid || mem_addr != p_addr || mem_data != p_data)) stab_err++;
    if (ev_ready && mem_valid) overlap_err++;
    stall_prev = mem_valid && !mem_ready;
    p_addr = mem_addr; p_data = mem_data;
    if (mem_valid && mem_ready) begin mem_model[mem_addr] = mem_data; wr_count++; end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] getm(input logic [39:0] a);
    return mem_model.exists(a) ? mem_model[a] : 32'hxxxx_xxxx;
  endfunction

  task automatic settle(); repeat (2) @(negedge clk); endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a;
    @(negedge clk); d = reg_rdata;
  endtask

  task automatic set_ctrl(input logic [31:0] v);
    wr(3'd0, v);
    ovfdet_on = v[2]; wb_on = v[3];
    if (v[5]) exp_ovf = 0;
    settle();
  endtask

  task automatic set_rptr(input logic [31:0] v);
    wr(3'd2, v); exp_rptr = v; settle();
  endtask

  task automatic push(input logic [7:0] s, input logic [27:0] d, input logic [7:0] r,
                      input logic [7:0] v, input logic [15:0] p, input string tag);
    logic [39:0] a;
    a = {BASEV, 8'h00} + 40'(exp_wptr);
    for (int k = 0; k < 4; k++) mem_model.delete(a + 40'(4*k));
    mem_model.delete(WBA);
    @(negedge clk);
    while (!ev_ready) @(negedge clk);
    ev_valid = 1; ev_src_id = s; ev_src_data = d; ev_ring_id = r; ev_vm_id = v; ev_pasid = p;
    @(negedge clk); ev_valid = 0;
    while (!ev_ready) @(negedge clk);
    settle();
    chk({tag, " word0"}, getm(a),      {24'h0, s});
    chk({tag, " word1"}, getm(a + 4),  {4'h0, d});
    chk({tag, " word2"}, getm(a + 8),  {p, v, r});
    chk({tag, " word3"}, getm(a + 12), 32'h0);
    exp_wptr = (exp_wptr + 16) % RING_BYTES;
    if (ovfdet_on && exp_wptr == exp_rptr) exp_ovf = 1;
    if (wb_on) chk("R6 writeback word", getm(WBA), exp_wptr | 32'(exp_ovf));
  endtask

  task automatic push_rand(input string tag);
    push(8'($urandom), 28'($urandom), 8'($urandom), 8'($urandom), 16'($urandom), tag);
  endtask

  task automatic chk_wptr(input string tag);
    logic [31:0] d;
    rd(3'd3, d);
    chk(tag, d, exp_wptr | 32'(exp_ovf));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++; n_err++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int cnt0, seen;
    void'($urandom(32'd9127));
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R12 reset state
    chk("R12 ev_ready", ev_ready, 0);
    chk("R12 irq", irq, 0);
    chk("R12 mem_valid", mem_valid, 0);
    chk("R12 busy", busy, 0);
    rd(3'd0, d); chk("R12 ctrl reads 0", d, 0);
    rd(3'd3, d); chk("R12 wptr reads 0", d, 0);

    wr(3'd1, BASEV);
    set_ctrl(C_RING | C_INTR | C_OVF | C_SIZE);
    rd(3'd0, d); chk("R13 ctrl readback", d, C_RING | C_INTR | C_OVF | C_SIZE);
    // R1 R3 directed first vector at ring base
    push(8'hA5, 28'hFFF_FFFF, 8'h3C, 8'h7E, 16'hBEEF, "R1/R3");
    chk_wptr("R2 wptr after one vector");
    chk("R8 irq on pending", irq, 1);
    chk("R10 busy on pending", busy, 1);
    set_rptr(32'd16);
    chk("R8 irq after consume", irq, 0);
    chk("R10 busy after consume", busy, 0);

    // random traffic with wraparound, reader keeps up (R2)
    for (int i = 0; i < 12; i++) begin
      push_rand("R1 random");
      chk_wptr("R2 wptr random");
      set_rptr(exp_wptr);
    end

    // R4 overflow: reader stalled, one full ring of vectors
    for (int i = 0; i < 3; i++) push_rand("R1 fill");
    chk_wptr("R4 no overflow yet");
    push_rand("R4 filling vector");
    chk("R4 overflow expected", exp_ovf, 1);
    chk_wptr("R4 overflow flag in wptr");
    push_rand("R4 overwrite oldest");
    chk_wptr("R5 flag sticky");
    set_ctrl(C_RING | C_INTR | C_OVF | C_SIZE | C_CLR);
    chk_wptr("R5 flag cleared");

    // R6 writeback including overflow bit
    wr(3'd4, WBA[31:0]); wr(3'd5, 32'(WBA[39:32]));
    set_ctrl(C_RING | C_INTR | C_OVF | C_WB | C_SIZE);
    for (int i = 0; i < 4; i++) push_rand("R6 vector");
    chk("R6 overflow reached", exp_ovf, 1);
    set_ctrl(C_RING | C_INTR | C_OVF | C_SIZE | C_CLR);
    set_rptr(exp_wptr);

    // R9 re-arm keeps irq up on partial consume
    set_ctrl(C_RING | C_INTR | C_OVF | C_REARM | C_SIZE);
    push_rand("R9 vector"); push_rand("R9 vector");
    set_rptr((exp_rptr + 16) % RING_BYTES);
    chk("R9 irq kept by rearm", irq, 1);
    set_rptr(exp_wptr);
    chk("R9 irq drops when equal", irq, 0);

    // R8 no re-arm: partial consume disarms
    set_ctrl(C_RING | C_INTR | C_OVF | C_SIZE);
    push_rand("R8 vector"); push_rand("R8 vector");
    set_rptr((exp_rptr + 16) % RING_BYTES);
    chk("R8 irq disarmed", irq, 0);
    chk("R10 busy with pending", busy, 1);
    set_rptr(exp_wptr);

    // R8 interrupt enable off
    set_ctrl(C_RING | C_OVF | C_SIZE);
    push_rand("R8 vector");
    chk("R8 irq gated by enable", irq, 0);
    set_rptr(exp_wptr);

    // R7 ring disabled: offered events ignored
    set_ctrl(C_SIZE);
    cnt0 = wr_count; seen = 0;
    @(negedge clk); ev_valid = 1;
    for (int i = 0; i < 10; i++) begin @(negedge clk); if (ev_ready) seen++; end
    ev_valid = 0; settle();
    chk("R7 ready low when disabled", seen, 0);
    chk("R7 no writes when disabled", wr_count, cnt0);
    chk_wptr("R7 wptr unchanged when disabled");

    // R2 software reset of pointers
    wr(3'd3, 32'h0); exp_wptr = 0; set_rptr(0);
    chk_wptr("R2 wptr reloaded to zero");
    chk("R10 busy idle", busy, 0);

    chk("R7 ready never with request", overlap_err, 0);
    chk("R11 request stable under stall", stab_err, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end
endmodule